// File: doc/BRIEF.md
# Byte Load Lane Formatter

This block carries out a single-byte load whose result is written into a 32-bit SIMD register. When idle it accepts an instruction word together with the base address and the current contents of the destination register. It forms the address by adding a sign-extended 8-bit displacement to the base. It then raises a one-byte read request on a simple request/response memory port and holds it until the data comes back.

A 3-bit pattern field decides what happens to the returned byte. Four patterns drop the byte into one byte lane and leave the other three lanes of the old register value as they were. The other four patterns spread the byte over the whole word in one of several forms: zero-extended halves, upper-byte halves, sign-extended halves, or a full four-lane copy. The new value leaves the block as a one-cycle register write pulse. A register file outside the block absorbs that pulse. Register index 0 is never written.

Top module: `byte_lane_loader`

## Requirements
- R1: After reset, busy, mem_req and wr_en are all low.
- R2: mem_addr equals base_value plus insn_word[17:10] read as a signed 8-bit value, wrapping at the address width.
- R3: mem_req rises in the cycle after an instruction is accepted. It stays high with mem_addr unchanged until mem_rvalid is seen, and it is low in the cycle after that.
- R4: wr_en is high for exactly one cycle, the cycle after mem_rvalid, and wr_idx then equals insn_word[9:6].
- R5: Pattern insn_word[20:18] = 0, 1, 2 or 3 writes the byte into bits [8n+7:8n] for n equal to the pattern. The other three bytes of old_value, as sampled when the instruction was accepted, are kept.
- R6: Pattern 4 writes 0x00BB00BB, where BB is the byte.
- R7: Pattern 5 writes 0xBB00BB00.
- R8: Pattern 6 writes the byte sign-extended into each 16-bit half. For example, 0x80 gives 0xFF80FF80 and 0x12 gives 0x00120012.
- R9: Pattern 7 writes 0xBBBBBBBB.
- R10: With destination index 0 the read still takes place, but wr_en stays low.
- R11: busy is high from the cycle after acceptance through the write cycle. While busy is high, insn_valid is ignored and has no effect on the request, the address or the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn_valid | input | 1 | Instruction offered; taken when busy is low |
| insn_word | input | 32 | Instruction: destination [9:6], displacement [17:10], pattern [20:18] |
| base_value | input | ADDR_W | Base address value |
| old_value | input | 32 | Current contents of the destination register |
| busy | output | 1 | An instruction is in progress |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | ADDR_W | Byte read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data byte |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 4 | Register write index |
| wr_data | output | 32 | Register write value |

## Verification
All four insert patterns use the same old value with distinct bytes, 0x11223344. Any mix-up of lane position, or a lane lost from the old value, therefore shows up in a different byte of the result. The widening patterns use the bytes 0x80 and 0x12. These tell sign extension apart from zero extension in the high half-words and tell upper-byte placement apart from lower-byte placement. Displacements 0xFC, 0x7F and 0x80 near a small base test the sign of the offset and wrap-around. Two further cases cover the response delay and the refusal of a second instruction while busy: a zero-latency response and a long one, and a competing instruction offered mid-transaction.

// File: rtl/bll_pkg.sv
package bll_pkg;
    localparam int LANE_W  = 8;
    localparam int LANES   = 4;
    localparam int WORD_W  = LANE_W * LANES;
    localparam int IDX_W   = 4;
    localparam int OFF_W   = 8;
    localparam int PAT_W   = 3;

    // instruction field positions
    localparam int DEST_LSB = 6;
    localparam int OFF_LSB  = 10;
    localparam int PAT_LSB  = 18;

    localparam logic [PAT_W-1:0] PAT_ZHALF = 3'd4;
    localparam logic [PAT_W-1:0] PAT_HHALF = 3'd5;
    localparam logic [PAT_W-1:0] PAT_SHALF = 3'd6;
    localparam logic [PAT_W-1:0] PAT_QUAD  = 3'd7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_WRITE = 2'd2
    } bll_state_e;
endpackage

// File: rtl/bll_addr_gen.sv
module bll_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] addr
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_ext;

    assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
    assign addr     = base + disp_ext;
endmodule

// File: rtl/bll_lane_fmt.sv
module bll_lane_fmt
    import bll_pkg::*;
(
    input  logic [LANE_W-1:0] byte_in,
    input  logic [PAT_W-1:0]  pat,
    input  logic [WORD_W-1:0] old_word,
    output logic [WORD_W-1:0] new_word
);
    localparam int HALF_W = 2 * LANE_W;
    localparam int HALVES = LANES / 2;

    logic [WORD_W-1:0] ins_word;
    logic [HALF_W-1:0] zhalf;
    logic [HALF_W-1:0] hhalf;
    logic [HALF_W-1:0] shalf;

    // lane insertion: one lane replaced, the rest kept
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign ins_word[g*LANE_W +: LANE_W] =
            (pat == PAT_W'(g)) ? byte_in : old_word[g*LANE_W +: LANE_W];
    end

    assign zhalf = {{LANE_W{1'b0}}, byte_in};
    assign hhalf = {byte_in, {LANE_W{1'b0}}};
    assign shalf = {{LANE_W{byte_in[LANE_W-1]}}, byte_in};

    always_comb begin
        new_word = ins_word;
        unique case (pat)
            PAT_ZHALF: new_word = {HALVES{zhalf}};
            PAT_HHALF: new_word = {HALVES{hhalf}};
            PAT_SHALF: new_word = {HALVES{shalf}};
            PAT_QUAD:  new_word = {LANES{byte_in}};
            default:   new_word = ins_word;
        endcase
    end
endmodule

// File: rtl/byte_lane_loader.sv
module byte_lane_loader
    import bll_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_valid,
    input  logic [31:0]       insn_word,
    input  logic [ADDR_W-1:0] base_value,
    input  logic [WORD_W-1:0] old_value,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [LANE_W-1:0] mem_rdata,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [WORD_W-1:0] wr_data
);
    typedef struct packed {
        bll_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [IDX_W-1:0]  dest;
        logic [PAT_W-1:0]  pat;
        logic [WORD_W-1:0] old;
        logic              wr_en;
        logic [WORD_W-1:0] wr_data;
    } bll_regs_t;

    bll_regs_t r_q, r_d;

    logic [IDX_W-1:0]  f_dest;
    logic [OFF_W-1:0]  f_disp;
    logic [PAT_W-1:0]  f_pat;
    logic [ADDR_W-1:0] eff_addr;
    logic [WORD_W-1:0] fmt_word;
    logic              unused_insn_bits;

    assign f_dest = insn_word[DEST_LSB +: IDX_W];
    assign f_disp = insn_word[OFF_LSB  +: OFF_W];
    assign f_pat  = insn_word[PAT_LSB  +: PAT_W];
    assign unused_insn_bits = ^{insn_word[31:PAT_LSB+PAT_W], insn_word[DEST_LSB-1:0]};

    bll_addr_gen #(.ADDR_W(ADDR_W), .DISP_W(OFF_W)) i_addr (
        .base (base_value),
        .disp (f_disp),
        .addr (eff_addr)
    );

    bll_lane_fmt i_fmt (
        .byte_in  (mem_rdata),
        .pat      (r_q.pat),
        .old_word (r_q.old),
        .new_word (fmt_word)
    );

    always_comb begin
        r_d       = r_q;
        r_d.wr_en = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (insn_valid) begin
                    r_d.state = ST_WAIT;
                    r_d.addr  = eff_addr;
                    r_d.dest  = f_dest;
                    r_d.pat   = f_pat;
                    r_d.old   = old_value;
                end
            end
            ST_WAIT: begin
                if (mem_rvalid) begin
                    r_d.state   = ST_WRITE;
                    r_d.wr_en   = (r_q.dest != '0);
                    r_d.wr_data = fmt_word;
                end
            end
            ST_WRITE: r_d.state = ST_IDLE;
            default:  r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy     = (r_q.state != ST_IDLE);
    assign mem_req  = (r_q.state == ST_WAIT);
    assign mem_addr = r_q.addr;
    assign wr_en    = r_q.wr_en;
    assign wr_idx   = r_q.dest;
    assign wr_data  = r_q.wr_data;

    // request held with a stable address while no response
    p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));
    p_req_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_rvalid |=> !mem_req);
    // write strobe only right after a response
    p_write_after_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(mem_req && mem_rvalid));
    p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
    p_no_zero_dest_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_idx != '0);
    p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid && !busy |=> busy && mem_req);
    p_req_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
endmodule

// File: tb/test_byte_lane_loader.sv
module test_byte_lane_loader;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [31:0] insn_word = '0;
    logic [31:0] base_value = '0;
    logic [31:0] old_value = '0;
    logic        busy, mem_req, wr_en;
    logic [31:0] mem_addr, wr_data;
    logic        mem_rvalid = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic [3:0]  wr_idx;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_lane_loader #(.ADDR_W(32)) i_byte_lane_loader (
        .clk, .rst_n, .insn_valid, .insn_word, .base_value, .old_value,
        .busy, .mem_req, .mem_addr, .mem_rvalid, .mem_rdata,
        .wr_en, .wr_idx, .wr_data
    );

    function automatic logic [31:0] mk_insn(input logic [3:0] dest,
                                            input logic [7:0] disp,
                                            input logic [2:0] pat);
        return (32'd5 << 21) | (32'(pat) << 18) | (32'(disp) << 10) | (32'(dest) << 6);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // one complete load; delay = cycles of waiting before the response
    task automatic run_load(input string req, input logic [3:0] dest,
                            input logic [7:0] disp, input logic [2:0] pat,
                            input logic [31:0] base, input logic [31:0] old,
                            input logic [7:0] data, input int delay,
                            input logic [31:0] exp_addr, input logic [31:0] exp_data);
        insn_word  = mk_insn(dest, disp, pat);
        base_value = base;
        old_value  = old;
        insn_valid = 1'b1;
        step();
        insn_valid = 1'b0;
        old_value  = 32'hDEAD_BEEF;
        chk({req, " R11 busy"}, 32'(busy), 32'd1);
        chk({req, " R3 req"}, 32'(mem_req), 32'd1);
        chk({req, " R2 addr"}, mem_addr, exp_addr);
        for (int i = 0; i < delay; i++) begin
            step();
            chk({req, " R3 held"}, {31'd0, mem_req}, 32'd1);
            chk({req, " R3 addr stable"}, mem_addr, exp_addr);
            chk({req, " R4 no early write"}, 32'(wr_en), 32'd0);
        end
        mem_rvalid = 1'b1;
        mem_rdata  = data;
        step();
        mem_rvalid = 1'b0;
        mem_rdata  = 8'h5A;
        chk({req, " R3 req drop"}, 32'(mem_req), 32'd0);
        chk({req, " R11 busy in write"}, 32'(busy), 32'd1);
        if (dest == 4'd0) begin
            chk({req, " R10 no write"}, 32'(wr_en), 32'd0);
        end else begin
            chk({req, " R4 wr_en"}, 32'(wr_en), 32'd1);
            chk({req, " R4 wr_idx"}, 32'(wr_idx), 32'(dest));
            chk({req, " data"}, wr_data, exp_data);
        end
        step();
        chk({req, " R4 one pulse"}, 32'(wr_en), 32'd0);
        chk({req, " R11 done"}, 32'(busy), 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 req", 32'(mem_req), 32'd0);
        chk("R1 wr_en", 32'(wr_en), 32'd0);
    endtask

    task automatic t_insert();
        run_load("R5 lane0", 4'd3, 8'h04, 3'd0, 32'h1000, 32'h1122_3344, 8'hAB, 0, 32'h1004, 32'h1122_33AB);
        run_load("R5 lane1", 4'd4, 8'h00, 3'd1, 32'h1000, 32'h1122_3344, 8'hAB, 2, 32'h1000, 32'h1122_AB44);
        run_load("R5 lane2", 4'd5, 8'hFC, 3'd2, 32'h1000, 32'h1122_3344, 8'hAB, 1, 32'h0FFC, 32'h11AB_3344);
        run_load("R5 lane3", 4'd15, 8'h7F, 3'd3, 32'h1000, 32'h1122_3344, 8'hAB, 5, 32'h107F, 32'hAB22_3344);
    endtask

    task automatic t_widen();
        run_load("R6 zhalf", 4'd1, 8'h01, 3'd4, 32'h2000, 32'hFFFF_FFFF, 8'h80, 0, 32'h2001, 32'h0080_0080);
        run_load("R7 hhalf", 4'd2, 8'h02, 3'd5, 32'h2000, 32'hFFFF_FFFF, 8'h12, 1, 32'h2002, 32'h1200_1200);
        run_load("R8 shalf neg", 4'd6, 8'h03, 3'd6, 32'h2000, 32'h0, 8'h80, 0, 32'h2003, 32'hFF80_FF80);
        run_load("R8 shalf pos", 4'd7, 8'h03, 3'd6, 32'h2000, 32'hFFFF_FFFF, 8'h12, 3, 32'h2003, 32'h0012_0012);
        run_load("R9 quad", 4'd8, 8'h80, 3'd7, 32'h0000_0002, 32'h0, 8'hC3, 2, 32'hFFFF_FF82, 32'hC3C3_C3C3);
    endtask

    task automatic t_zero_dest();
        run_load("R10 dest0", 4'd0, 8'h10, 3'd7, 32'h3000, 32'h0, 8'h77, 1, 32'h3010, 32'h0);
    endtask

    // competing instruction while busy must not change anything
    task automatic t_busy_refuse();
        insn_word  = mk_insn(4'd9, 8'h08, 3'd0);
        base_value = 32'h4000;
        old_value  = 32'hA0B0_C0D0;
        insn_valid = 1'b1;
        step();
        insn_word  = mk_insn(4'd10, 8'h20, 3'd7);
        base_value = 32'h9000;
        old_value  = 32'h0;
        step();
        chk("R11 addr kept", mem_addr, 32'h4008);
        step();
        chk("R11 addr kept late", mem_addr, 32'h4008);
        mem_rvalid = 1'b1;
        mem_rdata  = 8'h3C;
        step();
        mem_rvalid = 1'b0;
        insn_valid = 1'b0;
        chk("R11 idx first", 32'(wr_idx), 32'd9);
        chk("R11 data first", wr_data, 32'hA0B0_C03C);
        step();
        step();
        chk("R11 no second req", 32'(mem_req), 32'd0);
        chk("R11 idle", 32'(busy), 32'd0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_insert();
        t_widen();
        t_zero_dest();
        t_busy_refuse();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule